// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt requests from up to sixteen on-chip sources into a status register. It gates that register with a mask register and drives a single interrupt-pending line toward the CPU. Each source input is edge-detected, so a rising request marks its status bit. The bit then stays marked until software acknowledges it.

Software uses a small register port. It acknowledges sources by writing the status register: the written word is ANDed into the current contents, so a 0 clears a bit and a 1 leaves it alone. It enables sources by writing the mask register, which is replaced whole. The pending output is a registered OR over the bits that are both marked and enabled. It follows any change to either register one clock later. Source 3 is, by convention, the request from the DMA interrupt logic.

Top module: `irqc_top`

## Requirements
- R1: While reset is asserted and on the first cycle after, the status register, the mask register and `cpu_irq` are all zero.
- R2: A 0-to-1 transition on `irq_req[i]` sets status bit i on the clock edge that first samples the input high. A request held high does not set the bit again after it has been cleared.
- R3: A write to offset 0x0 stores the old status ANDed with `bus_wdata[15:0]`: a 1 in the written word keeps that bit, and a 0 clears it.
- R4: A write to offset 0x4 replaces the mask register with `bus_wdata[15:0]`.
- R5: `cpu_irq` is high exactly when the status AND mask of the previous cycle is non-zero. A change to either register shows on `cpu_irq` one clock later.
- R6: A source whose rising edge lands in the same cycle as a status write that clears its bit ends up set.
- R7: Reading offset 0x0 returns the status and reading offset 0x4 returns the mask, in `rd_data[15:0]`, with `rd_data[31:16]` zero. A read changes no state.
- R8: Each input bit i maps to status bit i, across all sixteen sources. Bit 3 is the request of the DMA interrupt logic.
- R9: Writes to any offset other than 0x0 and 0x4, and reads of such offsets, leave both registers unchanged, and those reads return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Byte offset in the block: 0x0 status, 0x4 mask |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data; bits 15:0 are used |
| rd_data | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | input | 16 | Per-source request lines |
| cpu_irq | output | 1 | Registered interrupt-pending line to the CPU |

## Verification
A corrupted status bit shows up on the next read of offset 0x0. If that bit is also enabled in the mask, it reaches `cpu_irq` one clock after the fault. A stale edge-detect register shows as a missed set or a repeated set on a held request. This is visible on the next status read after an acknowledge. A mask fault is seen directly on reads of offset 0x4 and through a wrong `cpu_irq` level one cycle later. The directed scenarios read both registers after each stimulus, so each fault is exposed within two clocks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // byte offsets the register port decodes
   localparam int unsigned OFS_STATUS = 0;
   localparam int unsigned OFS_MASK   = 4;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_MASK   = 2'd2
   } irqc_sel_e;

   function automatic irqc_sel_e irqc_decode(input logic [31:0] ofs);
      if (ofs == 32'(OFS_STATUS))    return SEL_STATUS;
      else if (ofs == 32'(OFS_MASK)) return SEL_MASK;
      else                           return SEL_NONE;
   endfunction
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
   parameter int NSRC = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req,
   output logic [NSRC-1:0] req_prev,
   output logic [NSRC-1:0] rise
);
   // one detector cell per source
   for (genvar g = 0; g < NSRC; g++) begin : g_cell
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= req[g];
      end
      assign req_prev[g] = prev_q;
      assign rise[g]     = req[g] & ~prev_q;
   end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NSRC   = 16,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [NSRC-1:0]   wdata,
   input  logic [NSRC-1:0]   rise,
   output logic [NSRC-1:0]   status,
   output logic [NSRC-1:0]   mask,
   output logic [BUS_W-1:0]  rdata
);
   localparam int PAD_W = BUS_W - NSRC;

   irqc_sel_e        sel;
   logic [NSRC-1:0]  status_d, mask_d, rd_src;

   assign sel = irqc_decode(32'(addr));

   always_comb begin
      // hardware set is ORed last so it wins over an acknowledge
      status_d = status;
      if (wr && sel == SEL_STATUS) status_d = status & wdata;
      status_d = status_d | rise;
      mask_d = mask;
      if (wr && sel == SEL_MASK) mask_d = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '0;
      end else begin
         status <= status_d;
         mask   <= mask_d;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_STATUS: rd_src = status;
         SEL_MASK:   rd_src = mask;
         default:    rd_src = '0;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign rdata = {{PAD_W{1'b0}}, rd_src};
   end else begin : g_nopad
      assign rdata = rd_src;
   end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
   parameter int NSRC = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] status,
   input  logic [NSRC-1:0] mask,
   output logic            pend
);
   logic [NSRC-1:0] live;
   assign live = status & mask;

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= |live;
   end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
   parameter int NSRC   = 16,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  rd_data,
   input  logic [NSRC-1:0]   irq_req,
   output logic              cpu_irq
);
   // elaboration-time parameter checks
   if (NSRC < 1 || NSRC > BUS_W) begin : g_bad_nsrc
      $error("irqc_top: NSRC must lie in 1..BUS_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("irqc_top: ADDR_W must reach offset 0x4");
   end

   logic [NSRC-1:0] status_w, mask_w, prev_w, rise_w;

   if (NSRC < BUS_W) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^bus_wdata[BUS_W-1:NSRC];
   end

   irqc_edge #(.NSRC(NSRC)) u_edge (
      .clk(clk), .rst_n(rst_n), .req(irq_req),
      .req_prev(prev_w), .rise(rise_w)
   );

   irqc_regs #(.NSRC(NSRC), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
      .wdata(bus_wdata[NSRC-1:0]), .rise(rise_w),
      .status(status_w), .mask(mask_w), .rdata(rd_data)
   );

   irqc_pend #(.NSRC(NSRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .status(status_w), .mask(mask_w),
      .pend(cpu_irq)
   );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int NSRC   = 16,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [NSRC-1:0]   wlo,
   input logic [NSRC-1:0]   irq_req,
   input logic [NSRC-1:0]   req_prev,
   input logic [NSRC-1:0]   status,
   input logic [NSRC-1:0]   mask,
   input logic              cpu_irq
);
   logic [NSRC-1:0] edge_v;
   logic            wr_st, wr_mk;
   assign edge_v = irq_req & ~req_prev;
   assign wr_st  = bus_wr && bus_addr == ADDR_W'(0);
   assign wr_mk  = bus_wr && bus_addr == ADDR_W'(4);

   // R5
   p_pend_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cpu_irq == (|($past(status) & $past(mask))));

   // R2 and R6: every detected edge leaves its bit set
   p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(edge_v) & ~status) == '0));

   // R2: no bit appears without an edge
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status) & ~$past(edge_v)) == '0));

   // R3
   p_ack_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_st |=> ((status & ~($past(status) & $past(wlo)) & ~$past(edge_v)) == '0));

   // R4
   p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mk |=> mask == $past(wlo));

   // R9
   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mk |=> $stable(mask));
endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .wlo(bus_wdata[NSRC-1:0]), .irq_req(irq_req), .req_prev(prev_w),
   .status(status_w), .mask(mask_w), .cpu_irq(cpu_irq)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd_data;
   logic [15:0] irq_req = '0;
   logic        cpu_irq;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   irqc_top dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .rd_data(rd_data), .irq_req(irq_req),
      .cpu_irq(cpu_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive a one-cycle write; returns at the following negedge
   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = rd_data;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      bus_read(3'h0, v); check("R1 status", v, 32'h0);
      bus_read(3'h4, v); check("R1 mask", v, 32'h0);
      check("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
   endtask

   task automatic t_walk();
      logic [31:0] v;
      for (int i = 0; i < 16; i++) begin
         irq_req = 16'(1) << i;
         @(negedge clk);
         bus_read(3'h0, v);
         check($sformatf("R8 R2 source %0d", i), v, 32'(1) << i);
         irq_req = '0;
         bus_write(3'h0, 32'h0);
      end
   endtask

   task automatic t_ack();
      logic [31:0] v;
      irq_req = 16'hA5C3; @(negedge clk); irq_req = '0; @(negedge clk);
      bus_write(3'h0, 32'hFFFF_00FF);
      bus_read(3'h0, v); check("R3 keep low byte", v, 32'h0000_00C3);
      bus_write(3'h0, 32'h0000_0003);
      bus_read(3'h0, v); check("R3 clear zeros", v, 32'h0000_0003);
      bus_write(3'h0, 32'h0);
   endtask

   task automatic t_mask_pend();
      logic [31:0] v;
      irq_req = 16'h0008; @(negedge clk); irq_req = '0; @(negedge clk);
      check("R5 unmasked low", {31'b0, cpu_irq}, 32'h0);
      bus_write(3'h4, 32'hDEAD_0008);
      bus_read(3'h4, v); check("R4 mask replace", v, 32'h0000_0008);
      check("R5 lag one clock", {31'b0, cpu_irq}, 32'h0);
      @(negedge clk);
      check("R5 pending high", {31'b0, cpu_irq}, 32'h1);
      bus_write(3'h4, 32'h0000_0100);
      bus_read(3'h4, v); check("R4 mask replace 2", v, 32'h0000_0100);
      check("R5 still high one clock", {31'b0, cpu_irq}, 32'h1);
      @(negedge clk);
      check("R5 masked off", {31'b0, cpu_irq}, 32'h0);
      bus_write(3'h4, 32'h0000_0008);
      @(negedge clk);
      check("R5 re-enabled", {31'b0, cpu_irq}, 32'h1);
      bus_write(3'h0, 32'h0);
      check("R5 ack lag", {31'b0, cpu_irq}, 32'h1);
      @(negedge clk);
      check("R5 ack drops", {31'b0, cpu_irq}, 32'h0);
      bus_write(3'h4, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      irq_req = 16'h0001; @(negedge clk);
      irq_req = 16'h0021;
      bus_write(3'h0, 32'h0);
      bus_read(3'h0, v); check("R6 set wins", v, 32'h0000_0020);
      irq_req = '0;
      bus_write(3'h0, 32'h0);
   endtask

   task automatic t_held();
      logic [31:0] v;
      irq_req = 16'h4000; @(negedge clk);
      bus_write(3'h0, 32'h0);
      @(negedge clk);
      bus_read(3'h0, v); check("R2 held no retrigger", v, 32'h0);
      irq_req = '0; @(negedge clk);
      irq_req = 16'h4000; @(negedge clk);
      bus_read(3'h0, v); check("R2 re-raise sets", v, 32'h0000_4000);
      irq_req = '0;
   endtask

   task automatic t_read_side();
      logic [31:0] v;
      bus_write(3'h4, 32'hFFFF_1234);
      for (int k = 0; k < 3; k++) begin
         bus_read(3'h0, v); @(negedge clk);
      end
      bus_read(3'h0, v); check("R7 status unchanged by reads", v, 32'h0000_4000);
      bus_read(3'h4, v); check("R7 upper half zero", v, 32'h0000_1234);
   endtask

   task automatic t_bad_ofs();
      logic [31:0] v;
      bus_write(3'h1, 32'h0);
      bus_write(3'h2, 32'h0);
      bus_write(3'h6, 32'hFFFF);
      bus_read(3'h0, v); check("R9 status kept", v, 32'h0000_4000);
      bus_read(3'h4, v); check("R9 mask kept", v, 32'h0000_1234);
      bus_read(3'h2, v); check("R9 unmapped read zero", v, 32'h0);
   endtask

   initial begin
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_walk();
      t_ack();
      t_mask_pend();
      t_collide();
      t_held();
      t_read_side();
      t_bad_ofs();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule